// File: doc/BRIEF.md
# PCI Interrupt Swizzle and Router

This block gathers the four level interrupt pins (A, B, C, D) of every device slot and folds them onto four shared interrupt lines. Each pin is rotated by its slot position, so that pin A of neighbouring slots lands on different shared lines. Four byte-wide routing registers then steer each shared line onto one of sixteen inputs of a legacy interrupt controller. Each controller input carries the logical OR of every shared line steered to it.

Software programs the routing bytes through a simple byte write port, using the same offsets that a configuration-space front end would decode. After reset every route is disabled, so nothing reaches the controller until software enables a route. The output vector is computed combinationally from the pins and the routing bytes, and it passes through one register before it leaves the block.

Top module: `pirq_router`

## Requirements
- R1: While reset is held, and in the first cycle after it, `irq_out` is all zero and all four routing bytes hold 0x80.
- R2: Slot index i (0-based, which is slot number i+1, so its slot offset is i) drives pin p (0 = A to 3 = D) on bit 4*i+p of `slot_irq`. That pin feeds shared line (p + i) mod 4.
- R3: A write with `cfg_we` high and `cfg_addr` equal to 0x60+k (k = 0..3) loads `cfg_wdata` into the routing byte of shared line k. The new route governs `irq_out` from the clock edge after the write edge.
- R4: A routing byte with bit 7 set disables its shared line, and that line then drives no output.
- R5: Bits 3:0 of an enabled routing byte select controller input 0 to 15. Bits 6:4 have no effect.
- R6: When several enabled shared lines are routed to the same controller input, that input is the OR of their levels.
- R7: A shared line is the OR of every slot pin that swizzles onto it.
- R8: Writes to any address outside 0x60 to 0x63, and cycles with `cfg_we` low, leave all routing bytes unchanged.
- R9: `irq_out` is registered. A pin level sampled at a clock edge appears on `irq_out` after that edge and stays until the next one.
- R10: Interrupts are level sensitive and active high. A controller input falls one edge after its last active source drops.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slot_irq | input | NUM_SLOTS*4 | Slot interrupt pin levels, bit 4*slot+pin |
| cfg_we | input | 1 | Routing byte write strobe |
| cfg_addr | input | 8 | Byte offset of the write |
| cfg_wdata | input | 8 | Routing byte value |
| irq_out | output | IRQ_W | Registered controller input levels |

## Verification
A routing byte that is stored wrongly, or a swizzle that computes the wrong index, shows up as a wrong bit of `irq_out` or a missing one. This becomes visible one edge after the first pin that uses the faulty path is raised. A corrupted byte stays invisible until a pin that maps to its shared line is active, so the stimulus sweeps every slot and pin under every route setting. It also keeps routes in place long enough that a stale or clobbered byte reaches the output. The bench compares the output against its own model on every cycle, so any discrepancy is reported in the cycle it appears.

// File: rtl/pirq_router_pkg.sv
// Package: shared constants, types and the slot swizzle function for
// the interrupt router. Assumes four pins per slot and four shared lines.
package pirq_router_pkg;
    localparam int PINS_PER_SLOT = 4;
    localparam int PIRQ_N        = 4;

    typedef logic [7:0] route_t;

    localparam route_t       ROUTE_RST  = 8'h80;
    localparam logic [7:0]   ROUTE_BASE = 8'h60;
    localparam int           OFF_BIT    = 7;

    // Shared line index for a pin of a slot: rotate by the slot offset.
    function automatic int pirq_of(input int slot_idx, input int pin);
        return (pin + slot_idx) % PIRQ_N;
    endfunction
endpackage

// File: rtl/pirq_swizzle.sv
// Module: ORs every slot pin onto its rotated shared line.
// Assumes slot index i carries slot offset i and pins are active high.
module pirq_swizzle
    import pirq_router_pkg::*;
#(
    parameter int NUM_SLOTS = 8
) (
    input  logic [NUM_SLOTS*PINS_PER_SLOT-1:0] slot_irq,
    output logic [PIRQ_N-1:0]                  pirq
);
    // Fold each pin onto the shared line picked by the swizzle.
    always_comb begin
        pirq = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            for (int p = 0; p < PINS_PER_SLOT; p++) begin
                if (slot_irq[i*PINS_PER_SLOT+p]) pirq[pirq_of(i, p)] = 1'b1;
            end
        end
    end

    // Spot-check the rotation of the last slot's pin A against an active line.
    always_comb begin
        // R2
        if (slot_irq[(NUM_SLOTS-1)*PINS_PER_SLOT]) begin
            last_slot_pina_chk: assert (pirq[(NUM_SLOTS-1) % PIRQ_N]);
        end
    end
endmodule

// File: rtl/pirq_route_regs.sv
// Module: the four routing bytes, one per shared line, loaded from a byte
// write port. Assumes the bytes sit at consecutive offsets from ROUTE_BASE.
module pirq_route_regs
    import pirq_router_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_we,
    input  logic [7:0] cfg_addr,
    input  logic [7:0] cfg_wdata,
    output route_t     route [PIRQ_N]
);
    for (genvar k = 0; k < PIRQ_N; k++) begin : g_reg
        localparam logic [7:0] MY_ADDR = ROUTE_BASE + 8'(k);

        // Hold or load this routing byte; reset leaves the route disabled.
        always_ff @(posedge clk) begin
            if (!rst_n)                              route[k] <= ROUTE_RST;
            else if (cfg_we && cfg_addr == MY_ADDR)  route[k] <= cfg_wdata;
        end

        // R8
        addr_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(cfg_we && cfg_addr == MY_ADDR) |=> $stable(route[k]));
    end
endmodule

// File: rtl/pirq_irq_mux.sv
// Module: steers each enabled shared line onto its selected controller
// input and ORs lines that share a target. Pure combinational.
module pirq_irq_mux
    import pirq_router_pkg::*;
#(
    parameter int IRQ_W = 16
) (
    input  logic [PIRQ_N-1:0] pirq,
    input  route_t            route [PIRQ_N],
    output logic [IRQ_W-1:0]  irq_comb
);
    localparam int IDX_W = $clog2(IRQ_W);

    // OR every active, enabled shared line into its target bit.
    always_comb begin
        irq_comb = '0;
        for (int q = 0; q < PIRQ_N; q++) begin
            if (pirq[q] && !route[q][OFF_BIT]) irq_comb[route[q][IDX_W-1:0]] = 1'b1;
        end
    end

    // Bits between the selector and the disable flag are don't-care.
    logic unused_route_bits;
    always_comb begin
        unused_route_bits = 1'b0;
        for (int q = 0; q < PIRQ_N; q++)
            unused_route_bits = unused_route_bits ^ (^route[q][OFF_BIT-1:IDX_W]);
    end
endmodule

// File: rtl/pirq_router.sv
// Module: top of the interrupt router. Swizzles slot pins onto four shared
// lines, routes them through programmable bytes, registers the result.
// Assumes synchronous active-low reset and level, active-high interrupts.
module pirq_router
    import pirq_router_pkg::*;
#(
    parameter int NUM_SLOTS = 8,
    parameter int IRQ_W     = 16
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NUM_SLOTS*PINS_PER_SLOT-1:0] slot_irq,
    input  logic                              cfg_we,
    input  logic [7:0]                        cfg_addr,
    input  logic [7:0]                        cfg_wdata,
    output logic [IRQ_W-1:0]                  irq_out
);
    logic [PIRQ_N-1:0] pirq;
    route_t            route [PIRQ_N];
    logic [IRQ_W-1:0]  irq_comb;
    logic [PIRQ_N*8-1:0] route_flat;

    pirq_swizzle #(.NUM_SLOTS(NUM_SLOTS)) u_swz (
        .slot_irq (slot_irq),
        .pirq     (pirq)
    );

    pirq_route_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .route     (route)
    );

    pirq_irq_mux #(.IRQ_W(IRQ_W)) u_mux (
        .pirq     (pirq),
        .route    (route),
        .irq_comb (irq_comb)
    );

    // Flatten the routing bytes for stability checks.
    always_comb begin
        for (int q = 0; q < PIRQ_N; q++) route_flat[q*8 +: 8] = route[q];
    end

    // Register the routed levels once before they leave the block.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_out <= '0;
        else        irq_out <= irq_comb;
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> irq_out == '0);

    // R4
    all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (route[0][OFF_BIT] && route[1][OFF_BIT] && route[2][OFF_BIT] && route[3][OFF_BIT])
        |=> irq_out == '0);

    // R10
    quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pirq == '0 |=> irq_out == '0);

    // R6
    fanout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(irq_out) <= PIRQ_N);

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $stable(slot_irq) && $stable(route_flat) |=> $stable(irq_out));
endmodule

// File: tb/sim_pirq_router.sv
`timescale 1ns/1ps
module sim_pirq_router;
    localparam int NS = 8;
    localparam int IW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS*4-1:0] slot_irq = '0;
    logic          cfg_we = 1'b0;
    logic [7:0]    cfg_addr = '0;
    logic [7:0]    cfg_wdata = '0;
    logic [IW-1:0] irq_out;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done  = 0;
    string tag   = "R1";

    logic [7:0]    m_route [4];
    logic [IW-1:0] m_exp;
    bit            m_valid = 0;

    pirq_router #(.NUM_SLOTS(NS), .IRQ_W(IW)) u0 (
        .clk(clk), .rst_n(rst_n), .slot_irq(slot_irq), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .irq_out(irq_out)
    );

    always #2.5 clk = ~clk;

    // Reference model: behavioural next-output computation at each edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_exp = '0;
            for (int q = 0; q < 4; q++) m_route[q] = 8'h80;
        end else begin
            logic [3:0]    lines;
            logic [IW-1:0] nxt;
            lines = '0;
            for (int s = 0; s < NS; s++)
                for (int p = 0; p < 4; p++)
                    if (slot_irq[s*4+p]) lines[(p+s)%4] = 1'b1;
            nxt = '0;
            for (int q = 0; q < 4; q++)
                if (lines[q] && !m_route[q][7]) nxt[m_route[q][3:0]] = 1'b1;
            m_exp = nxt;
            if (cfg_we && cfg_addr >= 8'h60 && cfg_addr <= 8'h63)
                m_route[cfg_addr-8'h60] = cfg_wdata;
        end
        m_valid = 1;
    end

    // Compare on every falling edge.
    always @(negedge clk) begin
        if (m_valid && !done) begin
            n_cmp++;
            if (irq_out !== m_exp) begin
                n_bad++;
                $display("FAIL %s: irq_out=%h expected=%h at %0t", tag, irq_out, m_exp, $time);
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic pins(input logic [NS*4-1:0] v, input int hold);
        @(negedge clk); slot_irq = v;
        repeat (hold) @(negedge clk);
    endtask

    initial begin
        // R1: reset state, then the first cycle after it
        tag = "R1";
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        pins('1, 3); // all routes off after reset, so still zero
        pins('0, 1);

        // R3: program distinct targets
        tag = "R3";
        wr(8'h60, 8'h03); wr(8'h61, 8'h05); wr(8'h62, 8'h0A); wr(8'h63, 8'h0F);

        // R2: sweep every slot and pin alone
        tag = "R2";
        for (int s = 0; s < NS; s++)
            for (int p = 0; p < 4; p++) begin
                logic [NS*4-1:0] v;
                v = '0; v[s*4+p] = 1'b1;
                pins(v, 2);
            end
        pins('0, 1);

        // R5: junk in bits 6:4
        tag = "R5";
        wr(8'h60, 8'h73); wr(8'h62, 8'h5C);
        for (int p = 0; p < 4; p++) pins(32'h1 << p, 2);

        // R8: writes outside the window and with strobe low
        tag = "R8";
        wr(8'h64, 8'h00); wr(8'h5F, 8'h00); wr(8'h00, 8'h81); wr(8'hE0, 8'h01);
        @(negedge clk); cfg_addr = 8'h61; cfg_wdata = 8'h80; @(negedge clk);
        for (int p = 0; p < 4; p++) pins(32'h1 << p, 2);

        // R6: all lines to one input
        tag = "R6";
        for (int q = 0; q < 4; q++) wr(8'h60 + 8'(q), 8'h07);
        for (int n = 0; n < 20; n++) pins($urandom, 1);

        // R4: disable two lines
        tag = "R4";
        wr(8'h61, 8'h87); wr(8'h63, 8'hFF);
        for (int p = 0; p < 4; p++) pins(32'h1 << p, 2);

        // R7 and R10: two pins on one line, drop one at a time
        tag = "R7";
        wr(8'h61, 8'h09);
        pins(32'h0000_0012, 2); // slot0 pin B and slot1 pin A -> line 1
        pins(32'h0000_0010, 2);
        tag = "R10";
        pins(32'h0000_0000, 2);

        // R9: random pins and writes
        tag = "R9";
        for (int n = 0; n < 400; n++) begin
            @(negedge clk);
            slot_irq = $urandom;
            cfg_we   = ($urandom % 4) == 0;
            cfg_addr = 8'h5E + 8'($urandom % 8);
            cfg_wdata = 8'($urandom);
        end
        @(negedge clk); cfg_we = 1'b0;
        repeat (3) @(negedge clk);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule